// File: doc/BRIEF.md
# FDR Run-Length Decompressor

This block rebuilds scan data from a serial stream of frequency-directed run-length code words. Each code word stands for a run of 0s closed by a single 1. The word has a prefix and a tail. The prefix is a string of 1s ended by a 0, and the number of prefix bits gives the group index `i`. The tail that follows has the same number of bits as the prefix and picks a member within the group. Group `i` holds 2^i run lengths, and its first member is 2^i − 2.

The source offers one code bit per cycle. A bit is taken only on a cycle where the decompressor asks for input (`req_o`) and the source marks the bit as present (`in_vld_i`). Once a full code word has arrived, the block stops asking for input. It then drives the decoded run on the output, one bit per cycle with `out_vld_o` high, to load a scan chain. The parameter `MAX_GRP` fixes the highest group the hardware supports. A prefix longer than that locks the block into an error state until reset.

Top module: `fdr_decomp`

## Requirements
- R1: After reset, `req_o` is 1, `out_vld_o` is 0 and `err_o` is 0.
- R2: A prefix of i−1 ones followed by a 0 selects group i (1 ≤ i ≤ `MAX_GRP`). Exactly i tail bits are read after it.
- R3: The decoded run length is 2^i − 2 plus the tail value. The tail is received MSB first, so 110010 decodes to a run of 8.
- R4: A run of length L appears as L cycles of `out_bit_o`=0 followed by one cycle of `out_bit_o`=1, with `out_vld_o` high on all L+1 consecutive cycles. `out_vld_o` is low on the cycle after the closing 1.
- R5: `req_o` is low on every cycle where `out_vld_o` is high, and no input bit is consumed during expansion.
- R6: A cycle with `in_vld_i`=0 consumes nothing, and `bit_in_i` is ignored on that cycle. Stalls anywhere inside a code word do not change the decoded runs.
- R7: The two-bit words 00 and 01 decode to runs of 0 and 1.
- R8: Group `MAX_GRP` decodes in full, up to the run length 2^(`MAX_GRP`+1) − 3.
- R9: A prefix with `MAX_GRP` leading ones sets `err_o`. From then until reset, `err_o` stays 1 and both `req_o` and `out_vld_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in_i | input | 1 | Serial code bit |
| in_vld_i | input | 1 | Code bit present this cycle |
| req_o | output | 1 | Decoder accepts a code bit this cycle |
| out_bit_o | output | 1 | Decoded scan bit |
| out_vld_o | output | 1 | Decoded scan bit is valid |
| err_o | output | 1 | Sticky flag for a prefix beyond the supported group |

## Verification
The assertions check these rules on every cycle:
- `req_o` is low whenever output is valid.
- Every zero of a run is followed by more output.
- The closing 1 is followed by an idle cycle.
- The error state is sticky and silent.

The correct run length for a given prefix and tail depends on the whole code word, so only the bench scenarios can show it. They compare random runs from every group, with and without input stalls, against lengths the bench encodes itself. They also cover the two-bit words, the extreme members of the top group, and recovery after an error.

// File: rtl/fdr_decomp.sv
module fdr_decomp #(
  parameter int MAX_GRP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in_i,
  input  logic in_vld_i,
  output logic req_o,
  output logic out_bit_o,
  output logic out_vld_o,
  output logic err_o
);
  localparam int PW = $clog2(MAX_GRP + 1);
  localparam int CW = MAX_GRP + 1;

  typedef enum logic [1:0] {S_PFX, S_TAIL, S_RUN, S_ERR} state_t;

  state_t             state;
  logic [PW-1:0]      ones;
  logic [PW-1:0]      grp;
  logic [PW-1:0]      tleft;
  logic [MAX_GRP-1:0] tacc;
  logic [CW-1:0]      cnt;

  logic               take;
  logic [MAX_GRP-1:0] tacc_n;
  logic [CW-1:0]      base;

  assign take      = req_o && in_vld_i;
  assign tacc_n    = {tacc[MAX_GRP-2:0], bit_in_i};
  assign base      = (CW'(1) << grp) - CW'(2);
  assign req_o     = (state == S_PFX) || (state == S_TAIL);
  assign out_vld_o = (state == S_RUN);
  assign out_bit_o = out_vld_o && (cnt == '0);
  assign err_o     = (state == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_PFX;
      ones  <= '0;
      grp   <= '0;
      tleft <= '0;
      tacc  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_PFX:
          if (take) begin
            if (bit_in_i) begin
              if (ones == PW'(MAX_GRP - 1)) state <= S_ERR;
              else ones <= ones + PW'(1);
            end else begin
              grp   <= ones + PW'(1);
              tleft <= ones + PW'(1);
              tacc  <= '0;
              state <= S_TAIL;
            end
          end
        S_TAIL:
          if (take) begin
            tacc  <= tacc_n;
            tleft <= tleft - PW'(1);
            if (tleft == PW'(1)) begin
              cnt   <= base + CW'(tacc_n);
              ones  <= '0;
              state <= S_RUN;
            end
          end
        S_RUN:
          if (cnt == '0) state <= S_PFX;
          else cnt <= cnt - CW'(1);
        default: state <= S_ERR;
      endcase
    end
  end

  assert_req_low_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> !req_o);
  assert_zero_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !out_bit_o) |=> out_vld_o);
  assert_gap_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && out_bit_o) |=> !out_vld_o);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!req_o && !out_vld_o));
endmodule

// File: tb/test_fdr_decomp.sv
`timescale 1ns/1ps
module test_fdr_decomp;
  localparam int G = 8;
  localparam int MAXRUN = (1 << (G + 1)) - 3;

  logic clk = 0, rst_n = 0, bit_in = 0, in_vld = 0;
  logic req, out_bit, out_vld, err;
  int checks = 0, fails = 0;
  bit sq[$];
  int eq[$];

  always #2.5 clk = ~clk;

  fdr_decomp #(.MAX_GRP(G)) i_fdr_decomp (
    .clk(clk), .rst_n(rst_n), .bit_in_i(bit_in), .in_vld_i(in_vld),
    .req_o(req), .out_bit_o(out_bit), .out_vld_o(out_vld), .err_o(err));

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic void enc(int l);
    int i = 1;
    int t;
    while (l > (1 << (i + 1)) - 3) i++;
    for (int k = 0; k < i - 1; k++) sq.push_back(1'b1);
    sq.push_back(1'b0);
    t = l - ((1 << i) - 2);
    for (int k = i - 1; k >= 0; k--) sq.push_back(t[k]);
    eq.push_back(l);
  endfunction

  task automatic run(int stall, string tag);
    int cyc = 0;
    int zc = 0;
    bit rq_bad = 0;
    while (eq.size() > 0 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (out_vld) begin
        if (req) rq_bad = 1;
        if (out_bit) begin
          int e = eq.pop_front();
          chk(zc == e, tag, zc, e);
          chk(!rq_bad, "R5 req low during expansion", rq_bad, 0);
          zc = 0;
          rq_bad = 0;
        end else zc++;
      end
      if (req && sq.size() > 0 && $urandom_range(99) >= stall) begin
        bit_in = sq.pop_front();
        in_vld = 1;
      end else begin
        in_vld = 0;
        bit_in = 1'($urandom_range(1));
      end
    end
    in_vld = 0;
    if (cyc >= 60000) chk(0, "watchdog expired", cyc, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; in_vld = 0; sq.delete(); eq.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req == 1, "R1 req after reset", req, 1);
    chk(out_vld == 0, "R1 out_vld after reset", out_vld, 0);
    chk(err == 0, "R1 err after reset", err, 0);
    rst_n = 1;
  endtask

  initial begin
    int bad;
    void'($urandom(32'h5eed_0f0d));
    do_reset();

    enc(0); enc(1); enc(0); enc(1);
    run(0, "R7 two-bit words");
    enc(8); enc(2); enc(5); enc(6); enc(13);
    run(0, "R3 directed runs");
    enc(MAXRUN); enc((1 << G) - 2); enc(MAXRUN - 1);
    run(0, "R8 top group");

    for (int n = 0; n < 200; n++) begin
      int g = $urandom_range(G, 1);
      enc((1 << g) - 2 + int'($urandom_range((1 << g) - 1)));
    end
    run(0, "R2 random groups");

    for (int n = 0; n < 100; n++) begin
      int g = $urandom_range(G, 1);
      enc((1 << g) - 2 + int'($urandom_range((1 << g) - 1)));
    end
    run(45, "R6 stalled input");

    for (int k = 0; k < G; k++) begin
      @(negedge clk);
      bit_in = 1; in_vld = 1;
    end
    @(negedge clk);
    chk(err == 1, "R9 err set", err, 1);
    chk(req == 0, "R9 req low", req, 0);
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      bit_in = 1'($urandom_range(1)); in_vld = 1;
      @(negedge clk);
      if (out_vld || req || !err) bad++;
    end
    in_vld = 0;
    chk(bad == 0, "R9 error state quiet and sticky", bad, 0);

    do_reset();
    enc(3); enc(0);
    run(0, "R2 decode after recovery");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule